// File: doc/BRIEF.md
# Double-Data-Rate Burst-of-Two SRAM Core

This block is a synthesizable model of a synchronous static memory whose data path runs at double data rate and moves every access as a fixed burst of two words. One command port serves reads and writes alike. When the load strobe is sampled low on a rising clock edge, that edge also captures the address and the direction. The two data beats that would travel on the clock and on its complement edge are modelled as two 36-bit words exchanged in the same clock cycle. Beat 0 belongs to one internal array and beat 1 to a second array of equal depth, and both beats use the loaded address.

Write data follows its command by one clock cycle. Each 36-bit beat is split into four 9-bit lanes, and each lane has its own active-low write enable for that beat. Read data appears `READ_LAT` clock edges after the read command. An output-enable flag (the stand-in for releasing the tri-state drivers) and a valid flag mark the data. A read issued on the edge that commits a write to the same address returns the newly written lanes. A synchronous reset empties the pipelines and leaves the arrays untouched.

Top module: `b2s_sram`

## Requirements
- R1: While `rst` is high and in the cycle after it, `q_valid` and `q_oe` are 0 and both read beats are all zero.
- R2: With `ld_n` high at an edge, no command starts: the data and lane-enable inputs of the next cycle change no stored word, and that edge produces no read output.
- R3: `ld_n` low with `rd_nwr` low at edge T starts a write to `addr`. The beats on `wd_beat0`/`wd_beat1` at edge T+1 are stored into array 0 and array 1 at that address.
- R4: Lane i (bits 9i+8 down to 9i, i = 0..3) of a beat is written only when bit i of that beat's enable (`wkeep0_n` or `wkeep1_n`) is 0. A lane whose enable bit is 1 keeps its old contents, and the enables of the two beats act independently.
- R5: `ld_n` low with `rd_nwr` high at edge T starts a read. In the cycle after edge T+`READ_LAT`, `q_beat0` holds the array 0 word and `q_beat1` holds the array 1 word at the loaded address. This lasts for exactly one cycle per read.
- R6: `q_oe` equals `q_valid` in every cycle, and both read beats are zero whenever `q_oe` is 0.
- R7: A command may be loaded on every edge, including a read or a write on the same edge that samples the data of the previous write.
- R8: A read loaded on the edge that samples a write's data, at the same address, returns the enabled lanes of that write merged with the old contents of the other lanes.
- R9: Reset does not alter stored words: data written before a reset reads back unchanged after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock; all sampling on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the pipelines |
| ld_n | input | 1 | Active-low load strobe starting a burst |
| rd_nwr | input | 1 | Access direction: 1 read, 0 write |
| addr | input | AW | Burst address, AW = clog2(DEPTH) |
| wd_beat0 | input | 36 | First write beat (array 0), one cycle after the write command |
| wd_beat1 | input | 36 | Second write beat (array 1), same cycle as beat 0 |
| wkeep0_n | input | 4 | Active-low lane write enables for beat 0 |
| wkeep1_n | input | 4 | Active-low lane write enables for beat 1 |
| q_beat0 | output | 36 | First read beat (array 0) |
| q_beat1 | output | 36 | Second read beat (array 1) |
| q_oe | output | 1 | Read drivers enabled; 0 means high impedance |
| q_valid | output | 1 | Read data present on both beats |

## Verification
Properties check several relations on every cycle. Output enable must track the valid flag, and the idle beats must be zero. A write enable may only follow a loaded write command, and no write may follow an edge with the strobe high. Lanes must be written or kept as their enable bits say, and each valid pulse must be backed by an outstanding read. The scenarios alone can show the rest. They confirm that the data returned is the right word after the right latency, that forwarding happens on the colliding edge, that ignored data leaves the arrays untouched when read back later, and that the stored contents survive a reset.

// File: rtl/b2s_pkg.sv
package b2s_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_mask_t;

    typedef struct packed {
        word_t b0;
        word_t b1;
    } burst_t;

    // Replace the lanes whose active-low enable is 0 with the new word.
    function automatic word_t merge_lanes(word_t old_w, word_t new_w, lane_mask_t keep_n);
        word_t r;
        r = old_w;
        for (int i = 0; i < LANES; i++) begin
            if (!keep_n[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/b2s_ctrl.sv
module b2s_ctrl #(
    parameter int AW       = 6,
    parameter int READ_LAT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_n,
    input  logic          rd_nwr,
    input  logic [AW-1:0] addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          rd_fire,
    output logic          q_valid
);
    localparam int STAGES = READ_LAT + 1;
    localparam int CW     = $clog2(STAGES + 2);

    logic [STAGES-1:0] vchain;
    logic [CW-1:0]     outst;

    assign rd_fire = !ld_n && rd_nwr;

    // Write data phase: one cycle after the command edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
        end else begin
            wr_en   <= !ld_n && !rd_nwr;
            wr_addr <= addr;
        end
    end

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) vchain <= '0;
                else     vchain <= rd_fire;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) vchain <= '0;
                else     vchain <= {vchain[STAGES-2:0], rd_fire};
            end
        end
    endgenerate

    assign q_valid = vchain[STAGES-1];

    // Count reads issued but not yet presented.
    always_ff @(posedge clk) begin
        if (rst) outst <= '0;
        else     outst <= outst + CW'(rd_fire) - CW'(q_valid);
    end

    p_valid_backed_r5: assert property (@(posedge clk) disable iff (rst)
        q_valid |-> (outst != '0));

    p_outst_bound_r5: assert property (@(posedge clk) disable iff (rst)
        outst <= CW'(STAGES));

endmodule

// File: rtl/b2s_bank.sv
module b2s_bank
    import b2s_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  lane_mask_t    wkeep_n,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    word_t mem [DEPTH];
    logic  hit;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= merge_lanes(mem[waddr], wdata, wkeep_n);
    end

    // Forward the data being committed on this edge to a colliding read.
    assign hit   = we && (waddr == raddr);
    assign rdata = hit ? merge_lanes(mem[raddr], wdata, wkeep_n) : mem[raddr];

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            p_lane_keep_r4: assert property (@(posedge clk) disable iff (rst)
                $past(we && wkeep_n[i]) |->
                    mem[$past(waddr)][i*LANE_W +: LANE_W] ==
                    $past(mem[waddr][i*LANE_W +: LANE_W]));

            p_lane_write_r3: assert property (@(posedge clk) disable iff (rst)
                $past(we && !wkeep_n[i]) |->
                    mem[$past(waddr)][i*LANE_W +: LANE_W] ==
                    $past(wdata[i*LANE_W +: LANE_W]));
        end
    endgenerate

endmodule

// File: rtl/b2s_rd_pipe.sv
module b2s_rd_pipe
    import b2s_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  burst_t din,
    output burst_t q,
    output logic   oe
);
    burst_t            st [STAGES];
    logic [STAGES-1:0] sv;

    always_ff @(posedge clk) begin
        if (rst) begin
            sv <= '0;
            for (int k = 0; k < STAGES; k++) st[k] <= '0;
        end else begin
            sv[0] <= load;
            st[0] <= load ? din : '0;
            for (int k = 1; k < STAGES; k++) begin
                sv[k] <= sv[k-1];
                st[k] <= st[k-1];
            end
        end
    end

    assign q  = st[STAGES-1];
    assign oe = sv[STAGES-1];

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !oe |-> (q == '0));

endmodule

// File: rtl/b2s_sram.sv
module b2s_sram
    import b2s_pkg::*;
#(
    parameter  int DEPTH    = 64,
    parameter  int READ_LAT = 2,
    localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_n,
    input  logic              rd_nwr,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wd_beat0,
    input  logic [WORD_W-1:0] wd_beat1,
    input  logic [LANES-1:0]  wkeep0_n,
    input  logic [LANES-1:0]  wkeep1_n,
    output logic [WORD_W-1:0] q_beat0,
    output logic [WORD_W-1:0] q_beat1,
    output logic              q_oe,
    output logic              q_valid
);
    localparam int STAGES = READ_LAT + 1;

    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic          rd_fire;
    word_t         wd  [2];
    lane_mask_t    wk  [2];
    word_t         rdw [2];
    burst_t        rd_burst;
    burst_t        q_burst;

    b2s_ctrl #(.AW(AW), .READ_LAT(READ_LAT)) u_ctrl (
        .clk(clk), .rst(rst), .ld_n(ld_n), .rd_nwr(rd_nwr), .addr(addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .rd_fire(rd_fire), .q_valid(q_valid)
    );

    assign wd[0] = wd_beat0;
    assign wd[1] = wd_beat1;
    assign wk[0] = wkeep0_n;
    assign wk[1] = wkeep1_n;

    generate
        for (genvar b = 0; b < 2; b++) begin : g_bank
            b2s_bank #(.DEPTH(DEPTH), .AW(AW)) u_bank (
                .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_addr),
                .wdata(wd[b]), .wkeep_n(wk[b]), .raddr(addr), .rdata(rdw[b])
            );
        end
    endgenerate

    assign rd_burst.b0 = rdw[0];
    assign rd_burst.b1 = rdw[1];

    b2s_rd_pipe #(.STAGES(STAGES)) u_pipe (
        .clk(clk), .rst(rst), .load(rd_fire), .din(rd_burst),
        .q(q_burst), .oe(q_oe)
    );

    assign q_beat0 = q_burst.b0;
    assign q_beat1 = q_burst.b1;

    p_oe_tracks_valid_r6: assert property (@(posedge clk) disable iff (rst)
        q_oe == q_valid);

    p_idle_no_write_r2: assert property (@(posedge clk) disable iff (rst)
        $past(ld_n) |-> !wr_en);

    p_write_source_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(!ld_n && !rd_nwr));

endmodule

// File: tb/b2s_sram_test.sv
module b2s_sram_test;
    localparam int DEPTH = 16;
    localparam int LAT   = 2;
    localparam int AW    = 4;
    localparam int HN    = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_n = 1'b1;
    logic          rd_nwr = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [35:0]   wd_beat0 = '0;
    logic [35:0]   wd_beat1 = '0;
    logic [3:0]    wkeep0_n = 4'hF;
    logic [3:0]    wkeep1_n = 4'hF;
    logic [35:0]   q_beat0;
    logic [35:0]   q_beat1;
    logic          q_oe;
    logic          q_valid;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    logic [35:0]   m0 [DEPTH];
    logic [35:0]   m1 [DEPTH];
    logic          pend_v = 1'b0;
    logic [AW-1:0] pend_a = '0;
    logic          hv [HN];
    logic [35:0]   h0 [HN];
    logic [35:0]   h1 [HN];

    always #10 clk = ~clk;

    b2s_sram #(.DEPTH(DEPTH), .READ_LAT(LAT)) uut (
        .clk(clk), .rst(rst), .ld_n(ld_n), .rd_nwr(rd_nwr), .addr(addr),
        .wd_beat0(wd_beat0), .wd_beat1(wd_beat1),
        .wkeep0_n(wkeep0_n), .wkeep1_n(wkeep1_n),
        .q_beat0(q_beat0), .q_beat1(q_beat1), .q_oe(q_oe), .q_valid(q_valid)
    );

    function automatic logic [35:0] lane_mix(logic [35:0] old_w, logic [35:0] new_w, logic [3:0] en_n);
        logic [35:0] r;
        for (int i = 0; i < 4; i++) begin
            r[i*9 +: 9] = en_n[i] ? old_w[i*9 +: 9] : new_w[i*9 +: 9];
        end
        return r;
    endfunction

    function automatic logic [35:0] rnd36();
        return {4'($urandom), 32'($urandom)};
    endfunction

    task automatic check(input string tag);
        int idx;
        logic ev;
        logic [35:0] e0, e1;
        idx = cyc - LAT;
        ev  = (idx >= 0) ? hv[idx % HN] : 1'b0;
        e0  = ev ? h0[idx % HN] : '0;
        e1  = ev ? h1[idx % HN] : '0;
        n_checks++;
        if (q_valid !== ev || q_oe !== ev || q_beat0 !== e0 || q_beat1 !== e1) begin
            n_fails++;
            $display("FAIL %s cyc=%0d actual v=%b oe=%b q0=%h q1=%h expected v=%b oe=%b q0=%h q1=%h",
                     tag, cyc, q_valid, q_oe, q_beat0, q_beat1, ev, ev, e0, e1);
        end
    endtask

    // One clock: cmd for this edge plus the data/enables sampled on it.
    task automatic step(input logic ldn, input logic rnw, input logic [AW-1:0] a,
                        input logic [35:0] d0, input logic [35:0] d1,
                        input logic [3:0] k0, input logic [3:0] k1, input string tag);
        ld_n = ldn; rd_nwr = rnw; addr = a;
        wd_beat0 = d0; wd_beat1 = d1; wkeep0_n = k0; wkeep1_n = k1;
        @(posedge clk);
        if (rst) begin
            pend_v = 1'b0;
            for (int i = 0; i < HN; i++) hv[i] = 1'b0;
        end else begin
            if (pend_v) begin
                m0[pend_a] = lane_mix(m0[pend_a], d0, k0);
                m1[pend_a] = lane_mix(m1[pend_a], d1, k1);
            end
            hv[cyc % HN] = 1'b0;
            if (!ldn && rnw) begin
                hv[cyc % HN] = 1'b1;
                h0[cyc % HN] = m0[a];
                h1[cyc % HN] = m1[a];
            end
            pend_v = !ldn && !rnw;
            pend_a = a;
        end
        @(negedge clk);
        check(tag);
        cyc++;
    endtask

    task automatic idle(input string tag);
        step(1'b1, 1'($urandom), AW'($urandom), rnd36(), rnd36(), 4'($urandom), 4'($urandom), tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < HN; i++) hv[i] = 1'b0;
        @(negedge clk);

        // R1: reset state
        rst = 1'b1;
        repeat (3) idle("R1");
        rst = 1'b0;
        idle("R1");

        // R3: fill every address back-to-back with full lanes
        for (int a = 0; a < DEPTH; a++)
            step(1'b0, 1'b0, AW'(a), rnd36(), rnd36(), 4'h0, 4'h0, "R3");
        step(1'b1, 1'b1, '0, rnd36(), rnd36(), 4'h0, 4'h0, "R3");

        // R5: read every address back-to-back
        for (int a = 0; a < DEPTH; a++)
            step(1'b0, 1'b1, AW'(a), rnd36(), rnd36(), 4'($urandom), 4'($urandom), "R5");
        repeat (LAT + 1) idle("R5");

        // R4: partial lane writes, independent per beat
        step(1'b0, 1'b0, 4'd3, rnd36(), rnd36(), 4'hF, 4'hF, "R4");
        step(1'b1, 1'b1, 4'd0, rnd36(), rnd36(), 4'b0101, 4'b1010, "R4");
        step(1'b0, 1'b0, 4'd4, rnd36(), rnd36(), 4'hF, 4'hF, "R4");
        step(1'b1, 1'b1, 4'd0, rnd36(), rnd36(), 4'hF, 4'b0111, "R4");
        step(1'b0, 1'b1, 4'd3, rnd36(), rnd36(), 4'h0, 4'h0, "R4");
        step(1'b0, 1'b1, 4'd4, rnd36(), rnd36(), 4'h0, 4'h0, "R4");
        repeat (LAT + 1) idle("R4");

        // R2: strobe high, full-lane data on the ports, then read back
        for (int i = 0; i < 6; i++)
            step(1'b1, 1'($urandom), AW'(5 + (i % 2)), rnd36(), rnd36(), 4'h0, 4'h0, "R2");
        step(1'b0, 1'b1, 4'd5, rnd36(), rnd36(), 4'h0, 4'h0, "R2");
        step(1'b0, 1'b1, 4'd6, rnd36(), rnd36(), 4'h0, 4'h0, "R2");
        repeat (LAT + 1) idle("R2");

        // R8: read on the edge that commits a write to the same address
        step(1'b0, 1'b0, 4'd9, rnd36(), rnd36(), 4'h0, 4'h0, "R8");
        step(1'b0, 1'b1, 4'd9, rnd36(), rnd36(), 4'b0110, 4'b1001, "R8");
        step(1'b0, 1'b0, 4'd9, rnd36(), rnd36(), 4'h0, 4'h0, "R8");
        step(1'b0, 1'b0, 4'd9, rnd36(), rnd36(), 4'b0011, 4'b0000, "R8");
        step(1'b0, 1'b1, 4'd9, rnd36(), rnd36(), 4'b1100, 4'b1110, "R8");
        repeat (LAT + 1) idle("R8");

        // R7: alternate write and read every edge
        for (int i = 0; i < 40; i++)
            step(1'b0, 1'(i % 2), AW'($urandom), rnd36(), rnd36(), 4'($urandom), 4'($urandom), "R7");
        repeat (LAT + 1) idle("R7");

        // R6: random traffic
        for (int i = 0; i < 3000; i++)
            step(($urandom % 10) < 3, 1'($urandom), AW'($urandom), rnd36(), rnd36(),
                 4'($urandom), 4'($urandom), "R6");
        repeat (LAT + 1) idle("R6");

        // R9: reset with reads in flight, then contents still present
        step(1'b0, 1'b1, 4'd2, rnd36(), rnd36(), 4'h0, 4'h0, "R1");
        rst = 1'b1;
        idle("R1");
        idle("R1");
        rst = 1'b0;
        for (int a = 0; a < DEPTH; a++)
            step(1'b0, 1'b1, AW'(a), rnd36(), rnd36(), 4'h0, 4'h0, "R9");
        repeat (LAT + 1) idle("R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule